// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the status byte of a serial nonvolatile memory and decides whether a status-write request is honoured. It holds three nonvolatile bits: a pin-protect enable bit and two block-protect bits. It also owns the write-enable latch. The block mirrors the busy flag of the internal write cycle as a write-in-progress bit.

A command engine upstream decodes the serial traffic. It sends single-cycle set-latch and clear-latch strobes. It marks a status-write sequence with a level signal that stays high for the whole sequence, and it raises a request strobe in the final cycle of that sequence. The active-low protect pin is watched through the whole sequence. If the pin was low at any moment and the stored enable bit is set, the request is refused.

An accepted request updates the nonvolatile bits and pulses an accept output, which starts the internal write cycle elsewhere. From then on the pin cannot affect the stored value. The status byte can be read in any cycle, including during a write cycle.

Top module: `stat_guard`

## Requirements
- R1: After reset, the status byte reads 0x00 while busy is low, bp_o is 0, and neither accept_o nor reject_o is high.
- R2: Status-byte bit 1 is the write-enable latch. A set strobe makes it 1 and a clear strobe makes it 0, one clock edge after the strobe. If both strobes arrive in the same cycle, the latch ends at 0. Both strobes are ignored while busy is high.
- R3: A request that is accepted pulses accept_o for one cycle, one edge after the request. On that same edge, status bits 7, 3 and 2 take the matching request data bits. Data bits 6:4, 1 and 0 are ignored, and status bits 6:4 always read 0.
- R4: A request is refused when the write-enable latch is 0 or when busy is high. A refused request pulses reject_o for one cycle, one edge after the request, and leaves bits 7, 3 and 2 unchanged.
- R5: A request is also refused when stored bit 7 is 1 and the protect pin was low in any cycle of the current sequence, the final request cycle included. The memory of a low pin is cleared once the sequence level drops, so a later sequence with the pin high is accepted.
- R6: While stored bit 7 is 0, the protect pin has no effect on acceptance.
- R7: While busy is high, changes on the protect pin or on requests do not alter bits 7, 3 and 2.
- R8: Status bit 0 equals the busy input in the same cycle, and the status byte can be read in every cycle.
- R9: The write-enable latch reads 0 from the first clock edge at which busy is seen low after being high.
- R10: bp_o always equals status bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wel_set_i | input | 1 | Strobe that sets the write-enable latch |
| wel_clr_i | input | 1 | Strobe that clears the write-enable latch |
| wrsr_seq_i | input | 1 | High throughout a status-write sequence |
| wrsr_req_i | input | 1 | Status-write request, in the final sequence cycle |
| wrsr_data_i | input | 8 | Requested status byte |
| wp_n_i | input | 1 | Protect pin level, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| status_o | output | 8 | Status byte for reads |
| wel_o | output | 1 | Write-enable latch state |
| bp_o | output | 2 | Block-protect bits |
| accept_o | output | 1 | Pulse: status write accepted, start write cycle |
| reject_o | output | 1 | Pulse: status write refused |

## Verification
The accept and reject pulses, the stored nonvolatile bits and the latch all change on the edge that follows their stimulus. Status bit 0 follows busy within the same cycle. Inputs are driven on the falling edge. For each stimulus the driver queues the expected byte, the expected block-protect bits and the expected pulse flags, all tagged for the next rising edge. The monitor compares them 5 ns after that edge, so every registered result is checked exactly one edge after its cause and the combinational busy mirror is checked while busy is held.

// File: rtl/stat_guard_pkg.sv
// Package: field positions of the status byte and the type of the
// nonvolatile part. Assumes an 8-bit status byte with two protect bits.
package stat_guard_pkg;
    localparam int SR_W      = 8;
    localparam int BP_W      = 2;
    localparam int BIT_WIP   = 0;
    localparam int BIT_WEL   = 1;
    localparam int BIT_BP_LO = 2;
    localparam int BIT_PEN   = SR_W - 1;

    typedef struct packed {
        logic            pen;
        logic [BP_W-1:0] bp;
    } nv_bits_t;
endpackage

// File: rtl/stat_guard_wpwatch.sv
// Module: remembers whether the protect pin was low in any cycle of the
// current status-write sequence. blocked_o also covers the current cycle.
// Assumes seq_i stays high from the first sequence cycle to the request.
module stat_guard_wpwatch (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_i,
    input  logic wp_n_i,
    output logic blocked_o
);
    logic seen_low_q;

    // Purpose: sticky low-pin flag, cleared as soon as the sequence ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_low_q <= 1'b0;
        end else begin
            seen_low_q <= seq_i & (seen_low_q | ~wp_n_i);
        end
    end

    assign blocked_o = seen_low_q | ~wp_n_i;

    // R5: a low pin inside a sequence must be remembered
    a_r5_low_pin_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_i && !wp_n_i) |=> blocked_o);
    // R5: memory is dropped after the sequence ends with the pin high
    a_r5_memory_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_i && wp_n_i) |=> (wp_n_i |-> !blocked_o));
endmodule

// File: rtl/stat_guard_wel.sv
// Module: write-enable latch. Set and clear strobes are honoured only while
// no write cycle runs, and the latch drops when the write cycle finishes.
// Assumes busy_i is a clean level from the write-cycle timer.
module stat_guard_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    output logic wel_o
);
    logic busy_q;

    // Purpose: latch update with priority clear > cycle-done > set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy_i;
            if (!busy_i) begin
                if (clr_i) begin
                    wel_o <= 1'b0;
                end else if (busy_q) begin
                    wel_o <= 1'b0;
                end else if (set_i) begin
                    wel_o <= 1'b1;
                end
            end
        end
    end

    // R2: set strobe in an idle cycle sets the latch
    a_r2_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && !busy_i && !busy_q) |=> wel_o);
    // R2: clear strobe wins when idle
    a_r2_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !busy_i) |=> !wel_o);
    // R2: strobes ignored during a write cycle
    a_r2_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(wel_o));
    // R9: end of write cycle drops the latch
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy_i) |=> !wel_o);
endmodule

// File: rtl/stat_guard_nvreg.sv
// Module: acceptance decision and storage of the nonvolatile status bits.
// Assumes req_i is a one-cycle strobe and blocked_i comes from the pin watcher.
module stat_guard_nvreg
    import stat_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  nv_bits_t        req_bits_i,
    input  logic            busy_i,
    input  logic            wel_i,
    input  logic            blocked_i,
    output nv_bits_t        nv_o,
    output logic            accept_o,
    output logic            reject_o
);
    logic ok;

    // Purpose: request is honoured only when idle, enabled and not pin-locked.
    always_comb begin
        ok = ~busy_i & wel_i & ~(nv_o.pen & blocked_i);
    end

    // Purpose: register the verdict pulses and commit accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_o     <= '0;
            accept_o <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            accept_o <= req_i & ok;
            reject_o <= req_i & ~ok;
            if (req_i && ok) begin
                nv_o <= req_bits_i;
            end
        end
    end

    // R7: nonvolatile bits frozen during a write cycle
    a_r7_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(nv_o));
    // R4: no latch means refusal and no change
    a_r4_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wel_i) |=> (reject_o && $stable(nv_o)));
    // R5: pin lock refuses the request
    a_r5_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && nv_o.pen && blocked_i) |=> !accept_o);
    // R3: accept and reject never together
    a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept_o, reject_o}));
    // R1: no verdict without a request
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!accept_o && !reject_o));
endmodule

// File: rtl/stat_guard.sv
// Module: top of the status-register guard. Joins the pin watcher, the
// write-enable latch and the nonvolatile store, and assembles the status byte.
// Assumes the command engine keeps the request inside the sequence level.
module stat_guard
    import stat_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wel_set_i,
    input  logic            wel_clr_i,
    input  logic            wrsr_seq_i,
    input  logic            wrsr_req_i,
    input  logic [7:0]      wrsr_data_i,
    input  logic            wp_n_i,
    input  logic            busy_i,
    output logic [7:0]      status_o,
    output logic            wel_o,
    output logic [1:0]      bp_o,
    output logic            accept_o,
    output logic            reject_o
);
    logic     blocked;
    nv_bits_t req_bits;
    nv_bits_t nv;
    logic     unused_data_bits;

    assign req_bits.pen     = wrsr_data_i[BIT_PEN];
    assign req_bits.bp      = wrsr_data_i[BIT_BP_LO +: BP_W];
    assign unused_data_bits = ^{wrsr_data_i[BIT_PEN-1:BIT_BP_LO+BP_W],
                                wrsr_data_i[BIT_WEL:BIT_WIP]};

    stat_guard_wpwatch u_wpwatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_i     (wrsr_seq_i),
        .wp_n_i    (wp_n_i),
        .blocked_o (blocked)
    );

    stat_guard_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wel_set_i),
        .clr_i  (wel_clr_i),
        .busy_i (busy_i),
        .wel_o  (wel_o)
    );

    stat_guard_nvreg u_nvreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (wrsr_req_i),
        .req_bits_i (req_bits),
        .busy_i     (busy_i),
        .wel_i      (wel_o),
        .blocked_i  (blocked),
        .nv_o       (nv),
        .accept_o   (accept_o),
        .reject_o   (reject_o)
    );

    // Purpose: assemble the readable status byte; unused bits read zero.
    always_comb begin
        status_o                        = '0;
        status_o[BIT_PEN]               = nv.pen;
        status_o[BIT_BP_LO +: BP_W]     = nv.bp;
        status_o[BIT_WEL]               = wel_o;
        status_o[BIT_WIP]               = busy_i;
    end

    assign bp_o = nv.bp;

    // R3: an accept pulse follows a request of the previous cycle
    a_r3_accept_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(wrsr_req_i));
endmodule

// File: tb/stat_guard_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver applies stimulus on the falling edge and
// queues the expected result for the next rising edge; the monitor checks it.
module stat_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wel_set, wel_clr, seq, req, wp_n, busy;
    logic [7:0] data;
    logic [7:0] status;
    logic       wel, accept, reject;
    logic [1:0] bp;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [7:0] st;
        logic       acc;
        logic       rej;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    stat_guard u_dut (
        .clk (clk), .rst_n (rst_n),
        .wel_set_i (wel_set), .wel_clr_i (wel_clr),
        .wrsr_seq_i (seq), .wrsr_req_i (req), .wrsr_data_i (data),
        .wp_n_i (wp_n), .busy_i (busy),
        .status_o (status), .wel_o (wel), .bp_o (bp),
        .accept_o (accept), .reject_o (reject)
    );

    // Driver: one cycle of stimulus plus its expected result.
    task automatic drv(input logic s, input logic c, input logic sq, input logic rq,
                       input logic [7:0] d, input logic wpn, input logic bz,
                       input logic [7:0] est, input logic acc, input logic rej,
                       input string tag);
        exp_t e;
        @(negedge clk);
        wel_set = s; wel_clr = c; seq = sq; req = rq; data = d; wp_n = wpn; busy = bz;
        e.due = cyc + 1; e.st = est; e.acc = acc; e.rej = rej; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare queued expectations due at this edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #5;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (status !== e.st || bp !== e.st[3:2] || wel !== e.st[1]
                || accept !== e.acc || reject !== e.rej) begin
                errors++;
                $display("FAIL %s: status=%h bp=%b wel=%b acc=%b rej=%b expected status=%h bp=%b acc=%b rej=%b",
                         e.tag, status, bp, wel, accept, reject, e.st, e.st[3:2], e.acc, e.rej);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        {wel_set, wel_clr, seq, req, busy} = '0;
        data = 8'h00; wp_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        drv(0,0,0,0,8'h00,1,0, 8'h00,0,0, "R1 reset");
        // R4 no latch
        drv(0,0,1,1,8'h8C,1,0, 8'h00,0,1, "R4 no latch");
        drv(0,0,0,0,8'h00,1,0, 8'h00,0,0, "R4 unchanged");
        // R2 latch control
        drv(1,0,0,0,8'h00,1,0, 8'h02,0,0, "R2 set");
        drv(0,1,0,0,8'h00,1,0, 8'h00,0,0, "R2 clear");
        drv(1,0,0,0,8'h00,1,0, 8'h02,0,0, "R2 set again");
        drv(1,1,0,0,8'h00,1,0, 8'h00,0,0, "R2 both strobes");
        drv(1,0,0,0,8'h00,1,0, 8'h02,0,0, "R2 set third");
        // R3 R10 accepted write, ignored bits
        drv(0,0,1,0,8'h00,1,0, 8'h02,0,0, "R3 seq");
        drv(0,0,1,0,8'h00,1,0, 8'h02,0,0, "R3 seq");
        drv(0,0,1,1,8'hFF,1,0, 8'h8E,1,0, "R3 R10 accept");
        // R8 mirror, R7 pin during busy, R4 busy refusal
        drv(0,0,0,0,8'h00,1,1, 8'h8F,0,0, "R8 busy mirror");
        drv(0,0,0,0,8'h00,0,1, 8'h8F,0,0, "R7 pin low while busy");
        drv(0,0,1,1,8'h00,0,1, 8'h8F,0,1, "R4 request while busy");
        drv(0,1,0,0,8'h00,1,1, 8'h8F,0,0, "R2 clear ignored busy");
        drv(0,0,0,0,8'h00,1,0, 8'h8C,0,0, "R9 latch drops");
        // R5 pin lock, low mid-sequence
        drv(1,0,0,0,8'h00,1,0, 8'h8E,0,0, "R2 set");
        drv(0,0,1,0,8'h00,0,0, 8'h8E,0,0, "R5 seq low");
        drv(0,0,1,0,8'h00,1,0, 8'h8E,0,0, "R5 seq high");
        drv(0,0,1,1,8'h00,1,0, 8'h8E,0,1, "R5 refused mid low");
        drv(0,0,0,0,8'h00,1,0, 8'h8E,0,0, "R5 unchanged");
        // R5 low only in the final cycle
        drv(0,0,1,0,8'h00,1,0, 8'h8E,0,0, "R5 seq");
        drv(0,0,1,1,8'h00,0,0, 8'h8E,0,1, "R5 refused final low");
        drv(0,0,0,0,8'h00,1,0, 8'h8E,0,0, "R5 idle");
        drv(0,0,1,1,8'h04,1,0, 8'h06,1,0, "R3 R10 accept pin high");
        drv(0,0,0,0,8'h00,1,1, 8'h07,0,0, "R8 busy");
        drv(0,0,0,0,8'h00,1,0, 8'h04,0,0, "R9 latch drops");
        // R6 enable bit clear: pin ignored
        drv(1,0,0,0,8'h00,1,0, 8'h06,0,0, "R2 set");
        drv(0,0,1,0,8'h00,0,0, 8'h06,0,0, "R6 seq low");
        drv(0,0,1,1,8'h88,0,0, 8'h8A,1,0, "R6 accepted with pin low");
        drv(0,0,0,0,8'h00,0,1, 8'h8B,0,0, "R8 busy");
        drv(0,0,0,0,8'h00,1,0, 8'h88,0,0, "R9 latch drops");
        // R5 lock again, then aborted sequence clears memory
        drv(1,0,0,0,8'h00,1,0, 8'h8A,0,0, "R2 set");
        drv(0,0,1,1,8'h00,0,0, 8'h8A,0,1, "R5 refused pin low");
        drv(0,0,1,0,8'h00,0,0, 8'h8A,0,0, "R5 aborted seq low");
        drv(0,0,0,0,8'h00,1,0, 8'h8A,0,0, "R5 seq ended");
        drv(0,0,1,1,8'h80,1,0, 8'h82,1,0, "R5 memory cleared, accept");
        drv(0,0,0,0,8'h00,1,0, 8'h82,0,0, "R3 final state");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule